// File: doc/BRIEF.md
# Dual-Edge Channel Interrupt Generator

This block raises the hardware interrupt request for one digital I/O channel. It watches two port C pins that have already been synchronised to the clock. A low-to-high change on the rise pin (bit 0 of port C) or a high-to-low change on the fall pin (bit 3 of port C) produces a request. A static per-channel mode decides whether requests are always allowed, never allowed, or allowed only while the gate pin (bit 4 of port C) is low.

No edge history is kept. Software that takes the interrupt finds the cause by reading the present levels of the two pins. Before another request can come from the same pin, software returns the rise pin to low and the fall pin to high. The request output is a single-cycle pulse with a matching drive-enable. Outside the tri-state pad, the line is released whenever no pulse is active, so several channels or boards can share one request wire. All pins of the block are plain control levels, so it has no valid/ready stream interface.

Top module: `dual_edge_irq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release with idle pin levels (rise pin 0, fall pin 1), `irq_req_o` and `irq_oe_o` are 0. Asserting reset clears an active pulse at once.
- R2: A rise pin sampled at 1 one clock after being sampled at 0 makes `irq_req_o` equal 1 for the cycle after that clock edge, if the interrupt is enabled.
- R3: A fall pin sampled at 0 one clock after being sampled at 1 makes `irq_req_o` equal 1 for the cycle after that clock edge, if the interrupt is enabled.
- R4: Each detected change gives exactly one cycle of request, even when the pin then stays at its new level.
- R5: A falling rise pin and a rising fall pin never produce a request.
- R6: With mode code 2'b01 (always on), requests occur whatever the level of the gate pin.
- R7: With mode code 2'b00 (off) or the reserved code 2'b11, no request occurs.
- R8: With mode code 2'b10 (gated), a change is honoured when the gate pin is low in the same sample as the change, and ignored when the gate pin is high.
- R9: A change that is ignored because the interrupt was disabled is dropped. It gives no request when the interrupt is enabled later.
- R10: `irq_oe_o` equals `irq_req_o` in every cycle, so the shared line is driven only during a pulse.
- R11: Changes on both pins in the same sample give one single-cycle request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc0_i | input | 1 | Synchronised rise pin level (port C bit 0) |
| pc3_i | input | 1 | Synchronised fall pin level (port C bit 3) |
| pc4_i | input | 1 | Synchronised gate pin level (port C bit 4) |
| mode_i | input | 2 | Enable mode: 00 off, 01 always on, 10 gated by pc4_i low, 11 off |
| irq_req_o | output | 1 | Interrupt request pulse, active high |
| irq_oe_o | output | 1 | Drive enable for the shared request line |

## Verification
The assertions assume that the pin inputs are already synchronous to `clk`, and that the pins rest at their idle levels (rise pin low, fall pin high) while reset is held. Without that, a level present at reset release would read as a change. The bench changes inputs only on the falling clock edge, holds the idle levels around every reset, and treats the mode as a quasi-static setting that it changes only between samples. It walks sequences that reach each pin transition under every mode code, with the gate pin both low and high.

// File: rtl/dual_edge_irq_pkg.sv
package dual_edge_irq_pkg;
  typedef enum logic [1:0] {
    IRQ_MODE_OFF  = 2'b00,
    IRQ_MODE_ON   = 2'b01,
    IRQ_MODE_GATE = 2'b10,
    IRQ_MODE_RSVD = 2'b11
  } irq_mode_e;

  localparam int unsigned IRQ_NSRC = 2;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  localparam logic IDLE_LVL = RISING ? 1'b0 : 1'b1;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= pin_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = pin_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~pin_i & prev_q;
    end
  endgenerate

  // A detected change cannot repeat on the very next sample (R4)
  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import dual_edge_irq_pkg::*;
#(
  parameter int unsigned NSRC = IRQ_NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  irq_mode_e       mode_i,
  input  logic            gate_lvl_i,
  input  logic [NSRC-1:0] hit_i,
  output logic            req_o,
  output logic            oe_o
);
  logic allow;
  logic req_q;

  always_comb begin
    case (mode_i)
      IRQ_MODE_ON:   allow = 1'b1;
      IRQ_MODE_GATE: allow = ~gate_lvl_i;
      default:       allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= allow & (|hit_i);
  end

  assign req_o = req_q;
  assign oe_o  = req_q;

  p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(|hit_i));

  p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == IRQ_MODE_OFF || mode_i == IRQ_MODE_RSVD) |=> !req_o);

  p_gate_high_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == IRQ_MODE_GATE && gate_lvl_i) |=> !req_o);
endmodule

// File: rtl/dual_edge_irq.sv
module dual_edge_irq
  import dual_edge_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pc0_i,
  input  logic       pc3_i,
  input  logic       pc4_i,
  input  logic [1:0] mode_i,
  output logic       irq_req_o,
  output logic       irq_oe_o
);
  logic [IRQ_NSRC-1:0] hit;
  irq_mode_e           mode;

  assign mode = irq_mode_e'(mode_i);

  irq_edge_det #(.RISING(1'b1)) u_rise (
    .clk(clk), .rst_n(rst_n), .pin_i(pc0_i), .edge_o(hit[0])
  );

  irq_edge_det #(.RISING(1'b0)) u_fall (
    .clk(clk), .rst_n(rst_n), .pin_i(pc3_i), .edge_o(hit[1])
  );

  irq_gate #(.NSRC(IRQ_NSRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .gate_lvl_i(pc4_i),
    .hit_i(hit), .req_o(irq_req_o), .oe_o(irq_oe_o)
  );

  // Line is driven only while a request is shown (R10)
  p_oe_tracks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe_o == irq_req_o);
endmodule

// File: tb/dual_edge_irq_tb_top.sv
module dual_edge_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic pc0, pc3, pc4;
  logic [1:0] mode;
  logic irq_req, irq_oe;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  dual_edge_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pc0_i(pc0), .pc3_i(pc3), .pc4_i(pc4),
    .mode_i(mode), .irq_req_o(irq_req), .irq_oe_o(irq_oe)
  );

  // Row: {mode[1:0], pc0, pc3, pc4, expected request, requirement number}
  localparam int NROWS = 29;
  localparam logic [9:0] VEC [NROWS] = '{
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1},  // idle, R1
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2},  // rise pin up, R2
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // held, R4
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // rise pin down, R5
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // fall pin down, R3
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // held, R4
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // fall pin up, R5
    {2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 4'd6},  // gate high ignored, R6
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // fall with gate high, R6
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2},  // rise with fall pin up, R2
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // fall only, R3
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // both back idle, R5
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 4'd11}, // both change, R11
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 4'd11}, // one cycle only, R11
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // idle, R5
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // off, rise, R7
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // off, fall, R7
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // off, idle, R7
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // reserved, rise, R7
    {2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // reserved, idle, R7
    {2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8},  // gated low, rise, R8
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // idle, R8
    {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8},  // gated high, rise, R8
    {2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 4'd9},  // enable later, dropped, R9
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},  // gated low, fall, R8
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // idle, gate high, R8
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8},  // gated high, fall, R8
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // enable later, dropped, R9
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}   // idle, R8
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #100000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pc0 = 1'b0; pc3 = 1'b1; pc4 = 1'b0; mode = 2'b01;
    repeat (3) @(negedge clk);
    check("R1 req in reset", irq_req, 1'b0);
    check("R1 oe in reset", irq_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after release", irq_req, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      mode = VEC[i][9:8];
      pc0  = VEC[i][7];
      pc3  = VEC[i][6];
      pc4  = VEC[i][5];
      @(negedge clk);
      check($sformatf("R%0d row %0d req", VEC[i][3:0], i), irq_req, VEC[i][4]);
      check($sformatf("R10 row %0d oe", i), irq_oe, irq_req);
    end

    // Reset during an active pulse clears it at once (R1)
    mode = 2'b01; pc0 = 1'b1;
    @(posedge clk);
    #1;
    check("R2 pulse before reset", irq_req, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1 req cleared by reset", irq_req, 1'b0);
    check("R1 oe cleared by reset", irq_oe, 1'b0);
    pc0 = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 quiet after second release", irq_req, 1'b0);
    finish_run();
  end
endmodule